// File: doc/BRIEF.md
# Paged Direct Operand Address Generator

This block turns the 7-bit offset carried in a single-word instruction into a full 16-bit data-memory operand address. It keeps two pieces of state: a 9-bit page register and a one-bit base-select flag. When the flag is clear, the page register is placed above the offset, so the 64K-word data space behaves as 512 pages of 128 words. When the flag is set, the offset is added as an unsigned number to a 16-bit stack pointer that the block receives from outside. Control strobes load the page register and set or clear the flag.

A separate register-access path forces the address into page 0. It ignores the page register, the stack pointer and the flag, so that control registers at the bottom of memory can always be reached. Every accepted request produces one registered address and a valid pulse in the following cycle. The output address keeps its last value between requests.

Top module: `dmem_addr_gen`

## Requirements
- R1: After reset, addr_o is 0x0000, addr_valid_o is 0, the page register is 0 and the base flag selects page mode.
- R2: In page mode, the address is {page[8:0], offset[6:0]}, where offset is instr_i[6:0]. A page of 2 with an offset of 1 gives 0x0101, and a page of 0x1FF with an offset of 0x7F gives 0xFFFF.
- R3: In stack mode, the address is sp_i + zero-extended offset, taken modulo 2^16. For example, 0xFFF0 + 0x7F gives 0x006F.
- R4: When reg_acc_i is 1 with a request, the address is {9'b0, offset}, whatever the page register, sp_i and the base flag hold.
- R5: instr_i[7] = 0 marks a direct operand. A request with instr_i[7] = 1 is ignored: addr_valid_o stays 0 and addr_o keeps its value. The bits instr_i[15:8] never affect the address.
- R6: addr_valid_o is 1 in the cycle after an accepted request and 0 otherwise. addr_o changes only in the cycle after an accepted request.
- R7: mode_set_i sets the base flag and mode_clr_i clears it. When both are asserted together, the clear wins. A flag change first affects a request made in the cycle after the strobe.
- R8: page_load_i loads page_data_i into the page register. A request in the same cycle as the load still uses the old page, and a request in the next cycle uses the new page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| page_load_i | input | 1 | Load strobe for the page register |
| page_data_i | input | 9 | New page number |
| mode_set_i | input | 1 | Select stack-relative base |
| mode_clr_i | input | 1 | Select page base (wins over set) |
| sp_i | input | 16 | Current stack pointer |
| req_i | input | 1 | Operand address request |
| instr_i | input | 16 | Instruction word; [6:0] offset, [7] direct marker |
| reg_acc_i | input | 1 | Register-access request, forces page 0 |
| addr_o | output | 16 | Registered operand address |
| addr_valid_o | output | 1 | addr_o holds a fresh address |

## Verification
The assertions check the following on every cycle:
- For each accepted request, the registered address against the page, stack or register-access formula, using the values sampled one cycle earlier.
- The one-cycle valid pulse and the holding of the address when no request is accepted.
- The response of the page register and the base flag to their strobes, including the rule that clear wins.

Only the bench scenarios can show the rest:
- The exact sample values of the page-mode example and the stack-pointer wrap.
- That a strobe and a request in the same cycle see the old page or the old flag.
- That register access stays in page 0 while the block is in stack mode with a full page register.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned OFS_W  = 7;
  localparam int unsigned INSTR_W = 16;

  typedef enum logic {
    BASE_PAGE  = 1'b0,
    BASE_STACK = 1'b1
  } base_mode_e;
endpackage

// File: rtl/dag_ctrl_regs.sv
module dag_ctrl_regs #(
  parameter int unsigned PAGE_W = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                page_load_i,
  input  logic [PAGE_W-1:0]   page_data_i,
  input  logic                mode_set_i,
  input  logic                mode_clr_i,
  output logic [PAGE_W-1:0]   page_o,
  output dag_pkg::base_mode_e mode_o
);
  import dag_pkg::*;

  logic [PAGE_W-1:0] page_q;
  base_mode_e        mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_clr_i)      mode_d = BASE_PAGE;
    else if (mode_set_i) mode_d = BASE_STACK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      mode_q <= BASE_PAGE;
    end else begin
      if (page_load_i) page_q <= page_data_i;
      mode_q <= mode_d;
    end
  end

  assign page_o = page_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/dag_addr_calc.sv
module dag_addr_calc #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFS_W  = 7
) (
  input  logic [ADDR_W-OFS_W-1:0] page_i,
  input  dag_pkg::base_mode_e     mode_i,
  input  logic [ADDR_W-1:0]       sp_i,
  input  logic [OFS_W-1:0]        ofs_i,
  input  logic                    reg_acc_i,
  output logic [ADDR_W-1:0]       addr_o
);
  import dag_pkg::*;
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ofs_ext;
  logic [ADDR_W-1:0] paged_addr;
  logic [ADDR_W-1:0] stack_addr;

  assign ofs_ext    = {{PAGE_W{1'b0}}, ofs_i};
  assign paged_addr = {page_i, ofs_i};
  // unsigned add, carry out discarded: wraps modulo 2^ADDR_W
  assign stack_addr = sp_i + ofs_ext;

  always_comb begin
    if (reg_acc_i)                addr_o = ofs_ext;
    else if (mode_i == BASE_STACK) addr_o = stack_addr;
    else                          addr_o = paged_addr;
  end
endmodule

// File: rtl/dag_out_reg.sv
module dag_out_reg #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen #(
  parameter int unsigned ADDR_W  = dag_pkg::ADDR_W,
  parameter int unsigned OFS_W   = dag_pkg::OFS_W,
  parameter int unsigned INSTR_W = dag_pkg::INSTR_W
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      page_load_i,
  input  logic [ADDR_W-OFS_W-1:0]   page_data_i,
  input  logic                      mode_set_i,
  input  logic                      mode_clr_i,
  input  logic [ADDR_W-1:0]         sp_i,
  input  logic                      req_i,
  input  logic [INSTR_W-1:0]        instr_i,
  input  logic                      reg_acc_i,
  output logic [ADDR_W-1:0]         addr_o,
  output logic                      addr_valid_o
);
  import dag_pkg::*;
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;
  localparam int unsigned DIR_BIT = OFS_W;

  logic [PAGE_W-1:0] page_q;
  base_mode_e        mode_q;
  logic [ADDR_W-1:0] addr_d;
  logic              accept;

  // bit just above the offset field: 0 marks a direct operand
  assign accept = req_i & ~instr_i[DIR_BIT];

  dag_ctrl_regs #(.PAGE_W(PAGE_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .page_load_i (page_load_i),
    .page_data_i (page_data_i),
    .mode_set_i  (mode_set_i),
    .mode_clr_i  (mode_clr_i),
    .page_o      (page_q),
    .mode_o      (mode_q)
  );

  dag_addr_calc #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_calc (
    .page_i    (page_q),
    .mode_i    (mode_q),
    .sp_i      (sp_i),
    .ofs_i     (instr_i[OFS_W-1:0]),
    .reg_acc_i (reg_acc_i),
    .addr_o    (addr_d)
  );

  dag_out_reg #(.ADDR_W(ADDR_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .addr_i  (addr_d),
    .addr_o  (addr_o),
    .valid_o (addr_valid_o)
  );
endmodule

// File: rtl/dmem_addr_gen_chk.sv
module dmem_addr_gen_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned OFS_W   = 7,
  parameter int unsigned INSTR_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    page_load_i,
  input logic [ADDR_W-OFS_W-1:0] page_data_i,
  input logic                    mode_set_i,
  input logic                    mode_clr_i,
  input logic [ADDR_W-1:0]       sp_i,
  input logic                    req_i,
  input logic [INSTR_W-1:0]      instr_i,
  input logic                    reg_acc_i,
  input logic [ADDR_W-1:0]       addr_o,
  input logic                    addr_valid_o,
  input logic [ADDR_W-OFS_W-1:0] page_q,
  input logic                    mode_q
);
  localparam int unsigned PAGE_W = ADDR_W - OFS_W;
  logic acc;
  assign acc = req_i && !instr_i[OFS_W];

  assert_page_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !reg_acc_i && !mode_q) |=> addr_o == {$past(page_q), $past(instr_i[OFS_W-1:0])});

  assert_stack_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !reg_acc_i && mode_q) |=>
      addr_o == ADDR_W'($past(sp_i) + {{PAGE_W{1'b0}}, $past(instr_i[OFS_W-1:0])}));

  assert_reg_page0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && reg_acc_i) |=> addr_o == {{PAGE_W{1'b0}}, $past(instr_i[OFS_W-1:0])});

  assert_valid_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> addr_valid_o);

  assert_idle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> (!addr_valid_o && $stable(addr_o)));

  assert_mode_clr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_clr_i |=> !mode_q);

  assert_mode_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_set_i && !mode_clr_i) |=> mode_q);

  assert_mode_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_set_i && !mode_clr_i) |=> $stable(mode_q));

  assert_page_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_load_i |=> page_q == $past(page_data_i));

  assert_page_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_load_i |=> $stable(page_q));
endmodule

bind dmem_addr_gen dmem_addr_gen_chk #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .INSTR_W(INSTR_W)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .page_load_i  (page_load_i),
  .page_data_i  (page_data_i),
  .mode_set_i   (mode_set_i),
  .mode_clr_i   (mode_clr_i),
  .sp_i         (sp_i),
  .req_i        (req_i),
  .instr_i      (instr_i),
  .reg_acc_i    (reg_acc_i),
  .addr_o       (addr_o),
  .addr_valid_o (addr_valid_o),
  .page_q       (page_q),
  .mode_q       (mode_q)
);

// File: tb/dmem_addr_gen_tb_top.sv
module dmem_addr_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        page_load_i = 1'b0;
  logic [8:0]  page_data_i = '0;
  logic        mode_set_i = 1'b0;
  logic        mode_clr_i = 1'b0;
  logic [15:0] sp_i = '0;
  logic        req_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic        reg_acc_i = 1'b0;
  logic [15:0] addr_o;
  logic        addr_valid_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dmem_addr_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .page_load_i(page_load_i), .page_data_i(page_data_i),
    .mode_set_i(mode_set_i), .mode_clr_i(mode_clr_i), .sp_i(sp_i), .req_i(req_i),
    .instr_i(instr_i), .reg_acc_i(reg_acc_i), .addr_o(addr_o), .addr_valid_o(addr_valid_o)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // one cycle of stimulus driven at negedge, returns at the next negedge
  task automatic step(bit pl, logic [8:0] pd, bit ms, bit mc, bit rq, logic [15:0] ins,
                      bit ra, logic [15:0] sp);
    page_load_i = pl; page_data_i = pd; mode_set_i = ms; mode_clr_i = mc;
    req_i = rq; instr_i = ins; reg_acc_i = ra; sp_i = sp;
    @(negedge clk_i);
    page_load_i = 1'b0; mode_set_i = 1'b0; mode_clr_i = 1'b0; req_i = 1'b0; reg_acc_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 addr", addr_o, 16'h0000);
    check("R1 valid", {15'b0, addr_valid_o}, 16'h0001 & 16'h0000);
    step(0, 0, 0, 0, 1, 16'h0055, 0, 16'hABCD);
    check("R1 page 0 page mode", addr_o, 16'h0055);
  endtask

  task automatic t_page_mode();
    step(1, 9'd2, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 16'h0001, 0, 16'h4000);
    check("R2 example", addr_o, 16'h0101);
    check("R6 valid", {15'b0, addr_valid_o}, 16'h0001);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check("R6 valid drop", {15'b0, addr_valid_o}, 16'h0000);
    check("R6 addr hold", addr_o, 16'h0101);
    step(1, 9'h1FF, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 16'hA37F, 0, 0);
    check("R2 max, R5 upper bits", addr_o, 16'hFFFF);
  endtask

  task automatic t_page_timing();
    step(1, 9'd5, 0, 0, 1, 16'h0003, 0, 0);
    check("R8 same cycle old page", addr_o, 16'hFF83);
    step(0, 0, 0, 0, 1, 16'h0003, 0, 0);
    check("R8 next cycle new page", addr_o, 16'h0283);
  endtask

  task automatic t_stack_mode();
    step(0, 0, 1, 0, 1, 16'h0010, 0, 16'h1000);
    check("R7 set same cycle page", addr_o, 16'h0290);
    step(0, 0, 0, 0, 1, 16'h0010, 0, 16'h1000);
    check("R3 stack sum", addr_o, 16'h1010);
    step(0, 0, 0, 0, 1, 16'h007F, 0, 16'hFFF0);
    check("R3 wrap", addr_o, 16'h006F);
  endtask

  task automatic t_reg_access();
    step(1, 9'h1FF, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 16'h7745, 1, 16'h8000);
    check("R4 page 0 in stack mode", addr_o, 16'h0045);
    check("R4 valid", {15'b0, addr_valid_o}, 16'h0001);
  endtask

  task automatic t_indirect_ignored();
    step(0, 0, 0, 0, 1, 16'h00A0, 0, 16'h2000);
    check("R5 no valid", {15'b0, addr_valid_o}, 16'h0000);
    check("R5 addr hold", addr_o, 16'h0045);
  endtask

  task automatic t_mode_priority();
    step(0, 0, 1, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 16'h0001, 0, 16'h3000);
    check("R7 clear wins", addr_o, 16'hFF81);
    step(0, 0, 1, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 1, 16'h0002, 0, 16'h3000);
    check("R7 clear same cycle stack", addr_o, 16'h3002);
    step(0, 0, 0, 0, 1, 16'h0002, 0, 16'h3000);
    check("R7 cleared page", addr_o, 16'hFF82);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_page_mode();
    t_page_timing();
    t_stack_mode();
    t_reg_access();
    t_indirect_ignored();
    t_mode_priority();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule